// File: doc/BRIEF.md
# Sliding-Piece Square-Control Evaluator

The block scores how much of the board each side's sliding pieces (bishops, rooks, queens) control, as one term of a position evaluation. A start pulse captures a full 64-square position into an internal register file. The position is then swept through a linear array of eight row cells, one column per cycle, from both ends at once. One stream walks the files left to right and carries rays that travel rightward. The other walks right to left and carries rays that travel leftward. Diagonal rays move up or down one row cell as they go. Rays along a file are resolved inside the column that the left stream is currently visiting.

Each controlled square earns its attacker a fixed weight. The weight is credited to White and debited to Black. Two exclusion rules apply: a bishop gets nothing for a square that holds a pawn of its own colour, and a queen gets nothing for a square that an enemy pawn attacks. Pawn attack maps are built from the position when it is captured. An eight-input adder folds the registered per-row values into an accumulator. The signed total appears with a one-cycle done pulse.

Top module: `sq_control_eval`

## Requirements
- R1: While rst_n is low, and after its release until the first result, done is 0 and score is 0.
- R2: A start sampled at a clock edge while the block is idle begins an evaluation of board_i at that edge. done is high for exactly the one cycle that begins 9 clock edges later. score carries the result from that cycle and holds it until the next result.
- R3: A start sampled during the 9 edges after an accepted start is ignored. It neither restarts nor alters the running evaluation, nor does it cause a second done.
- R4: The square at file c, rank r (0..7, rank 0 is White's back rank) is board_i[(8*c+r)*4 +: 4]. Bit 3 set means Black. Bits 2:0 encode the piece: 0 empty, 1 pawn, 2 knight, 3 bishop, 4 rook, 5 queen, 6 king.
- R5: Each square a piece controls scores 3 for a bishop (diagonals), 2 for a rook (ranks and files) and 1 for a queen (all eight directions). The score adds White's credits and subtracts Black's, as a 10-bit two's-complement value.
- R6: A ray stops at the first occupied square in its path. That square, whatever its occupant or colour, is still controlled unless R7 or R8 removes it.
- R7: A bishop earns nothing for a square holding a pawn of its own colour. The ray still stops there. A square holding an enemy pawn counts normally.
- R8: A queen earns nothing for a square attacked by an enemy pawn, and its ray continues past that square if it is empty. A White pawn on (c,r) attacks (c-1,r+1) and (c+1,r+1). A Black pawn attacks (c-1,r-1) and (c+1,r-1). Squares off the board are dropped and do not wrap. Pawns of the queen's own colour never exclude.
- R9: Pawns, knights and kings score nothing of their own, but they block rays as occupied squares.
- R10: A board with no sliding pieces scores 0. Contributions from both sides and all directions add independently, so the two opposite-direction streams together count every attacker-square pair exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an evaluation of board_i (ignored while busy) |
| board_i | input | 256 | Position, 4-bit code per square, layout per R4 |
| done | output | 1 | One-cycle pulse when score holds a new result |
| score | output | 10 | Signed control total, White positive |

## Verification
The bench aims at the points where a sweep of this kind tends to break. A ray that is not stopped at a blocker scores squares behind knights. A bishop that keeps its credit on its own pawn over-scores by exactly 3. A queen exclusion that uses the wrong pawn colour, or wraps pawn attacks across the board edge, shifts the total by single points. A leftward stream that drops or double-counts columns skews positions where Black and White attack from opposite sides. A second start pulse mid-sweep must not move the done pulse, change the total, or produce a second pulse. Randomly populated boards are compared with a square-walking model kept in the bench.

// File: rtl/sqc_pkg.sv
package sqc_pkg;
  localparam int PW = 4;

  typedef enum logic [2:0] {
    PC_NONE   = 3'd0,
    PC_PAWN   = 3'd1,
    PC_KNIGHT = 3'd2,
    PC_BISHOP = 3'd3,
    PC_ROOK   = 3'd4,
    PC_QUEEN  = 3'd5,
    PC_KING   = 3'd6
  } piece_e;

  localparam logic [1:0] RK_BISHOP = 2'd1;
  localparam logic [1:0] RK_ROOK   = 2'd2;
  localparam logic [1:0] RK_QUEEN  = 2'd3;

  // A ray in flight: who sent it and what kind of slider it is.
  typedef struct packed {
    logic       vld;
    logic       blk;
    logic [1:0] kind;
  } ray_t;

  // Ray that a piece on a square starts, for a diagonal or straight line.
  function automatic ray_t launch(logic [PW-1:0] pc, logic diag);
    ray_t ry;
    ry = '0;
    case (pc[2:0])
      PC_BISHOP: if (diag)  ry = '{vld: 1'b1, blk: pc[3], kind: RK_BISHOP};
      PC_ROOK:   if (!diag) ry = '{vld: 1'b1, blk: pc[3], kind: RK_ROOK};
      PC_QUEEN:  ry = '{vld: 1'b1, blk: pc[3], kind: RK_QUEEN};
      default:   ry = '0;
    endcase
    return ry;
  endfunction

  // Signed credit a ray earns on the square it reaches.
  function automatic logic signed [7:0] credit(ray_t ry, logic [PW-1:0] tgt,
                                               logic wp_hit, logic bp_hit,
                                               logic [7:0] wb, logic [7:0] wr,
                                               logic [7:0] wq);
    logic       skip;
    logic [7:0] w;
    skip = !ry.vld;
    if (ry.kind == RK_BISHOP && tgt[2:0] == PC_PAWN && tgt[3] == ry.blk) skip = 1'b1;
    if (ry.kind == RK_QUEEN && (ry.blk ? wp_hit : bp_hit)) skip = 1'b1;
    case (ry.kind)
      RK_BISHOP: w = wb;
      RK_ROOK:   w = wr;
      default:   w = wq;
    endcase
    if (skip) return 8'sd0;
    return ry.blk ? -$signed(w) : $signed(w);
  endfunction
endpackage

// File: rtl/sqc_ray_cell.sv
module sqc_ray_cell
  import sqc_pkg::*;
#(
  parameter int CELL_W = 8,
  parameter int W_B    = 3,
  parameter int W_R    = 2,
  parameter int W_Q    = 1
) (
  input  logic [PW-1:0]            piece,
  input  logic                     wp_hit,
  input  logic                     bp_hit,
  input  ray_t                     in_h,
  input  ray_t                     in_up,
  input  ray_t                     in_dn,
  output ray_t                     out_h,
  output ray_t                     out_up,
  output ray_t                     out_dn,
  output logic signed [CELL_W-1:0] val
);
  localparam logic [7:0] WB = 8'(W_B);
  localparam logic [7:0] WR = 8'(W_R);
  localparam logic [7:0] WQ = 8'(W_Q);

  logic occupied;
  assign occupied = (piece[2:0] != PC_NONE);

  // An occupied square ends every incoming ray and may start its own.
  assign out_h  = occupied ? launch(piece, 1'b0) : in_h;
  assign out_up = occupied ? launch(piece, 1'b1) : in_up;
  assign out_dn = occupied ? launch(piece, 1'b1) : in_dn;

  always_comb begin
    int sum;
    sum = int'(credit(in_h,  piece, wp_hit, bp_hit, WB, WR, WQ))
        + int'(credit(in_up, piece, wp_hit, bp_hit, WB, WR, WQ))
        + int'(credit(in_dn, piece, wp_hit, bp_hit, WB, WR, WQ));
    val = CELL_W'(sum);
  end
endmodule

// File: rtl/sqc_file_scan.sv
module sqc_file_scan
  import sqc_pkg::*;
#(
  parameter int N      = 8,
  parameter int CELL_W = 8,
  parameter int W_B    = 3,
  parameter int W_R    = 2,
  parameter int W_Q    = 1
) (
  input  logic [N*PW-1:0]     col,
  input  logic [N-1:0]        wp_col,
  input  logic [N-1:0]        bp_col,
  output logic [N*CELL_W-1:0] vals
);
  localparam logic [7:0] WB = 8'(W_B);
  localparam logic [7:0] WR = 8'(W_R);
  localparam logic [7:0] WQ = 8'(W_Q);

  // Rays along the file: every source row against every target row.
  always_comb begin
    vals = '0;
    for (int r = 0; r < N; r++) begin
      int   sum;
      sum = 0;
      for (int s = 0; s < N; s++) begin
        logic clear;
        int   lo;
        int   hi;
        lo    = (s < r) ? s : r;
        hi    = (s < r) ? r : s;
        clear = (s != r);
        for (int k = 0; k < N; k++)
          if (k > lo && k < hi && col[k*PW +: 3] != PC_NONE) clear = 1'b0;
        if (clear)
          sum += int'(credit(launch(col[s*PW +: PW], 1'b0), col[r*PW +: PW],
                             wp_col[r], bp_col[r], WB, WR, WQ));
      end
      vals[r*CELL_W +: CELL_W] = CELL_W'(sum);
    end
  end
endmodule

// File: rtl/sqc_pawn_map.sv
module sqc_pawn_map
  import sqc_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N*N*PW-1:0] board,
  output logic [N*N-1:0]    wp_att,
  output logic [N*N-1:0]    bp_att
);
  function automatic logic pawn_at(logic [N*N*PW-1:0] b, int c, int r, logic blk);
    logic [PW-1:0] pc;
    if (c < 0 || c >= N || r < 0 || r >= N) return 1'b0;
    pc = b[(c*N + r)*PW +: PW];
    return (pc[2:0] == PC_PAWN) && (pc[3] == blk);
  endfunction

  always_comb begin
    for (int c = 0; c < N; c++) begin
      for (int r = 0; r < N; r++) begin
        wp_att[c*N + r] = pawn_at(board, c-1, r-1, 1'b0) | pawn_at(board, c+1, r-1, 1'b0);
        bp_att[c*N + r] = pawn_at(board, c-1, r+1, 1'b1) | pawn_at(board, c+1, r+1, 1'b1);
      end
    end
  end
endmodule

// File: rtl/sq_control_eval.sv
module sq_control_eval
  import sqc_pkg::*;
#(
  parameter int N       = 8,
  parameter int SCORE_W = 10,
  parameter int CELL_W  = 8,
  parameter int W_B     = 3,
  parameter int W_R     = 2,
  parameter int W_Q     = 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [N*N*PW-1:0]         board_i,
  output logic                      done,
  output logic signed [SCORE_W-1:0] score
);
  localparam int SQ    = N*N;
  localparam int COL_W = N*PW;
  localparam int IDX_W = $clog2(N);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N-1);

  logic                      busy;
  logic                      stage_vld;
  logic                      accept;
  logic [IDX_W-1:0]          step;
  logic [IDX_W-1:0]          col_l;
  logic [IDX_W-1:0]          col_r;
  logic [SQ*PW-1:0]          board_q;
  logic [SQ-1:0]             wp_q, bp_q, wp_d, bp_d;
  logic [COL_W-1:0]          pcs_l, pcs_r;
  logic [N-1:0]              wp_l, bp_l, wp_r, bp_r;
  logic [N*CELL_W-1:0]       vflat;
  logic signed [SCORE_W-1:0] acc;
  logic signed [SCORE_W-1:0] tree_sum;

  ray_t lh_q [N];
  ray_t lu_q [N];
  ray_t ld_q [N];
  ray_t rh_q [N];
  ray_t ru_q [N];
  ray_t rd_q [N];
  ray_t lh_d [N];
  ray_t lu_d [N];
  ray_t ld_d [N];
  ray_t rh_d [N];
  ray_t ru_d [N];
  ray_t rd_d [N];

  logic signed [CELL_W-1:0] lval  [N];
  logic signed [CELL_W-1:0] rval  [N];
  logic signed [CELL_W-1:0] row_d [N];
  logic signed [CELL_W-1:0] row_q [N];

  assign accept = start && !busy && !stage_vld;
  assign col_l  = step;
  assign col_r  = LAST - step;

  // Register-file read ports: one column for each stream.
  assign pcs_l = board_q[col_l*COL_W +: COL_W];
  assign pcs_r = board_q[col_r*COL_W +: COL_W];
  assign wp_l  = wp_q[col_l*N +: N];
  assign bp_l  = bp_q[col_l*N +: N];
  assign wp_r  = wp_q[col_r*N +: N];
  assign bp_r  = bp_q[col_r*N +: N];

  sqc_pawn_map #(.N(N)) u_pawns (
    .board (board_i),
    .wp_att(wp_d),
    .bp_att(bp_d)
  );

  sqc_file_scan #(.N(N), .CELL_W(CELL_W), .W_B(W_B), .W_R(W_R), .W_Q(W_Q)) u_files (
    .col   (pcs_l),
    .wp_col(wp_l),
    .bp_col(bp_l),
    .vals  (vflat)
  );

  for (genvar r = 0; r < N; r++) begin : g_row
    ray_t lu_in, ld_in, ru_in, rd_in;

    if (r == 0) begin : g_bot
      assign lu_in = '0;
      assign ru_in = '0;
    end else begin : g_mid_b
      assign lu_in = lu_q[r-1];
      assign ru_in = ru_q[r-1];
    end

    if (r == N-1) begin : g_top
      assign ld_in = '0;
      assign rd_in = '0;
    end else begin : g_mid_t
      assign ld_in = ld_q[r+1];
      assign rd_in = rd_q[r+1];
    end

    sqc_ray_cell #(.CELL_W(CELL_W), .W_B(W_B), .W_R(W_R), .W_Q(W_Q)) u_lcell (
      .piece (pcs_l[r*PW +: PW]),
      .wp_hit(wp_l[r]),
      .bp_hit(bp_l[r]),
      .in_h  (lh_q[r]),
      .in_up (lu_in),
      .in_dn (ld_in),
      .out_h (lh_d[r]),
      .out_up(lu_d[r]),
      .out_dn(ld_d[r]),
      .val   (lval[r])
    );

    sqc_ray_cell #(.CELL_W(CELL_W), .W_B(W_B), .W_R(W_R), .W_Q(W_Q)) u_rcell (
      .piece (pcs_r[r*PW +: PW]),
      .wp_hit(wp_r[r]),
      .bp_hit(bp_r[r]),
      .in_h  (rh_q[r]),
      .in_up (ru_in),
      .in_dn (rd_in),
      .out_h (rh_d[r]),
      .out_up(ru_d[r]),
      .out_dn(rd_d[r]),
      .val   (rval[r])
    );

    assign row_d[r] = lval[r] + rval[r] + $signed(vflat[r*CELL_W +: CELL_W]);
  end

  // Eight-input adder over the registered row values.
  always_comb begin
    tree_sum = '0;
    for (int i = 0; i < N; i++) tree_sum += SCORE_W'(row_q[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      stage_vld <= 1'b0;
      step      <= '0;
      board_q   <= '0;
      wp_q      <= '0;
      bp_q      <= '0;
      acc       <= '0;
      score     <= '0;
      done      <= 1'b0;
      for (int i = 0; i < N; i++) begin
        lh_q[i]  <= '0;
        lu_q[i]  <= '0;
        ld_q[i]  <= '0;
        rh_q[i]  <= '0;
        ru_q[i]  <= '0;
        rd_q[i]  <= '0;
        row_q[i] <= '0;
      end
    end else begin
      done <= 1'b0;
      if (accept) begin
        board_q <= board_i;
        wp_q    <= wp_d;
        bp_q    <= bp_d;
        busy    <= 1'b1;
        step    <= '0;
        acc     <= '0;
        for (int i = 0; i < N; i++) begin
          lh_q[i] <= '0;
          lu_q[i] <= '0;
          ld_q[i] <= '0;
          rh_q[i] <= '0;
          ru_q[i] <= '0;
          rd_q[i] <= '0;
        end
      end else if (busy) begin
        for (int i = 0; i < N; i++) begin
          lh_q[i]  <= lh_d[i];
          lu_q[i]  <= lu_d[i];
          ld_q[i]  <= ld_d[i];
          rh_q[i]  <= rh_d[i];
          ru_q[i]  <= ru_d[i];
          rd_q[i]  <= rd_d[i];
          row_q[i] <= row_d[i];
        end
        step <= step + 1'b1;
        if (step == LAST) busy <= 1'b0;
      end

      stage_vld <= busy;
      if (stage_vld) begin
        acc <= acc + tree_sum;
        if (!busy) begin
          score <= acc + tree_sum;
          done  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sq_control_eval_chk.sv
module sq_control_eval_chk #(
  parameter int SCORE_W = 10
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic               done,
  input logic [SCORE_W-1:0] score
);
  logic [3:0] since;

  // Independent view of the run window: 0 idle, 1..9 edges since a start.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              since <= '0;
    else if (since == 4'd0)  since <= start ? 4'd1 : 4'd0;
    else if (since == 4'd9)  since <= 4'd0;
    else                     since <= since + 4'd1;
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (!done && score == '0));

  p_done_due_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (since == 4'd9) |=> done);

  p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_score_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(score) |-> done);

  p_no_stray_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (since == 4'd0 && $past(since) == 4'd9));
endmodule

bind sq_control_eval sq_control_eval_chk #(.SCORE_W(SCORE_W)) u_chk (
  .clk  (clk),
  .rst_n(rst_n),
  .start(start),
  .done (done),
  .score(score)
);

// File: tb/sq_control_eval_tb.sv
`timescale 1ns/1ps
module sq_control_eval_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [255:0] board_i = '0;
  logic         done;
  logic [9:0]   score;
  logic [255:0] brd;
  int           n_tests = 0;
  int           n_fail = 0;
  bit           finished = 0;

  always #10 clk = ~clk;

  sq_control_eval u_dut (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .board_i(board_i),
    .done   (done),
    .score  (score)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic logic [3:0] pc(input bit blk, input int kind);
    return {blk, 3'(kind)};
  endfunction

  task automatic put(input int c, input int r, input logic [3:0] code);
    brd[(c*8 + r)*4 +: 4] = code;
  endtask

  // Square-walking model of the scoring rules.
  function automatic int ref_score(input logic [255:0] b);
    bit wpa [8][8];
    bit bpa [8][8];
    int dc [8] = '{1, -1, 0, 0, 1, 1, -1, -1};
    int dr [8] = '{0, 0, 1, -1, 1, -1, 1, -1};
    int total = 0;
    for (int c = 0; c < 8; c++)
      for (int r = 0; r < 8; r++) begin
        wpa[c][r] = 0;
        bpa[c][r] = 0;
      end
    for (int c = 0; c < 8; c++)
      for (int r = 0; r < 8; r++) begin
        logic [3:0] p;
        p = b[(c*8 + r)*4 +: 4];
        if (p[2:0] == 3'd1) begin
          int tr;
          tr = p[3] ? r - 1 : r + 1;
          if (tr >= 0 && tr < 8) begin
            if (c > 0) begin if (p[3]) bpa[c-1][tr] = 1; else wpa[c-1][tr] = 1; end
            if (c < 7) begin if (p[3]) bpa[c+1][tr] = 1; else wpa[c+1][tr] = 1; end
          end
        end
      end
    for (int c = 0; c < 8; c++)
      for (int r = 0; r < 8; r++) begin
        logic [3:0] p;
        int k;
        int w;
        p = b[(c*8 + r)*4 +: 4];
        k = int'(p[2:0]);
        w = (k == 3) ? 3 : (k == 4) ? 2 : 1;
        if (k >= 3 && k <= 5)
          for (int d = 0; d < 8; d++) begin
            int  c2;
            int  r2;
            bit  stop;
            if (k == 3 && d < 4) continue;
            if (k == 4 && d >= 4) continue;
            c2 = c + dc[d];
            r2 = r + dr[d];
            stop = 0;
            while (!stop && c2 >= 0 && c2 < 8 && r2 >= 0 && r2 < 8) begin
              logic [3:0] t;
              bit ok;
              t = b[(c2*8 + r2)*4 +: 4];
              ok = 1;
              if (k == 3 && t[2:0] == 3'd1 && t[3] == p[3]) ok = 0;
              if (k == 5 && (p[3] ? wpa[c2][r2] : bpa[c2][r2])) ok = 0;
              if (ok) total += p[3] ? -w : w;
              if (t[2:0] != 3'd0) stop = 1;
              c2 += dc[d];
              r2 += dr[d];
            end
          end
      end
    return total;
  endfunction

  // Start one evaluation and check latency, pulse width and result.
  task automatic run_eval(input logic [255:0] b, input int expv, input string req,
                          input string what);
    int k;
    bit seen;
    @(negedge clk);
    board_i = b;
    start   = 1'b1;
    @(negedge clk);
    start = 1'b0;
    k = 1;
    seen = 0;
    while (k <= 20 && !seen) begin
      @(negedge clk);
      if (done) seen = 1;
      else k++;
    end
    check(seen && k == 9, "R2", "done latency in edges", k, 9);
    check($signed(score) == expv, req, what, $signed(score), expv);
    @(negedge clk);
    check(done == 1'b0, "R2", "done width", int'(done), 0);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R1", "done in reset", int'(done), 0);
    check(score == '0, "R1", "score in reset", int'(score), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(done == 1'b0 && score == '0, "R1", "idle after release", int'(score), 0);
  endtask

  task automatic t_lone_pieces;
    brd = '0;
    run_eval(brd, 0, "R10", "empty board");
    brd = '0; put(0, 0, pc(0, 4));
    run_eval(brd, 28, "R5", "white rook a1");
    brd = '0; put(3, 3, pc(0, 3));
    run_eval(brd, 39, "R5", "white bishop d4");
    brd = '0; put(3, 3, pc(1, 5));
    run_eval(brd, -27, "R5", "black queen d4 R4 sign bit");
  endtask

  task automatic t_blocking;
    brd = '0; put(0, 0, pc(0, 4)); put(0, 2, pc(1, 2));
    run_eval(brd, 18, "R6", "rook stopped by knight, R9 knight scores 0");
    brd = '0; put(0, 0, pc(0, 4)); put(7, 7, pc(1, 3));
    run_eval(brd, 7, "R10", "opposite corner sliders");
  endtask

  task automatic t_bishop_pawn;
    brd = '0; put(2, 0, pc(0, 3)); put(3, 1, pc(0, 1));
    run_eval(brd, 6, "R7", "bishop on own pawn");
    brd = '0; put(2, 0, pc(0, 3)); put(3, 1, pc(1, 1));
    run_eval(brd, 9, "R7", "bishop on enemy pawn");
  endtask

  task automatic t_queen_pawn;
    brd = '0; put(0, 0, pc(0, 5));
    run_eval(brd, 21, "R5", "white queen a1");
    brd = '0; put(0, 0, pc(0, 5)); put(2, 2, pc(1, 1));
    run_eval(brd, 15, "R8", "queen square hit by enemy pawn");
    brd = '0; put(0, 0, pc(0, 5)); put(2, 2, pc(0, 1));
    run_eval(brd, 16, "R8", "own pawn cover does not exclude");
    brd = '0; put(7, 0, pc(1, 5)); put(0, 1, pc(0, 1));
    run_eval(brd, -ref_score(brd) * -1, "R8", "pawn attack no wrap");
  endtask

  task automatic t_busy_start;
    logic [255:0] other;
    int k;
    bit seen;
    int extra;
    brd = '0; put(0, 0, pc(0, 4));
    other = '0; other[(3*8 + 3)*4 +: 4] = pc(1, 5);
    @(negedge clk);
    board_i = brd;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    k = 1;
    seen = 0;
    while (k <= 20 && !seen) begin
      @(negedge clk);
      if (k == 2) begin board_i = other; start = 1'b1; end
      else if (k == 3) start = 1'b0;
      if (done) seen = 1;
      else k++;
    end
    check(seen && k == 9, "R3", "done unmoved by busy start", k, 9);
    check($signed(score) == 28, "R3", "result unchanged by busy start", $signed(score), 28);
    extra = 0;
    repeat (14) begin
      @(negedge clk);
      if (done) extra++;
    end
    check(extra == 0, "R3", "no second done", extra, 0);
    check($signed(score) == 28, "R2", "score held after done", $signed(score), 28);
  endtask

  task automatic t_random;
    for (int i = 0; i < 8; i++) begin
      int np;
      brd = '0;
      np = 6 + (i % 6);
      for (int j = 0; j < np; j++) begin
        int kind;
        kind = int'($urandom_range(1, 6));
        if (i < 4 && kind < 3) kind = 5 - (j % 3);
        put(int'($urandom_range(0, 7)), int'($urandom_range(0, 7)),
            pc(bit'($urandom_range(0, 1)), kind));
      end
      run_eval(brd, ref_score(brd), "R6", "random board vs walk model");
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_lone_pieces();
    t_blocking();
    t_bishop_pawn();
    t_queen_pawn();
    t_busy_start();
    t_random();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule